// File: doc/BRIEF.md
# SPI Pin Role Override Logic

This block sits between a general-purpose I/O port and an SPI core. It takes four port pins, which are slave select, serial clock, master-out/slave-in and master-in/slave-out, and decides for each one how SPI mode changes its normal port behaviour. While the SPI is enabled, the pins that must be inputs in the current role are made inputs, whatever their direction bits say. Pins that carry data or clock out of the core take their output value from the core, but their direction bit still decides whether the pad is driven. On a pin that has been made an input, the port register bit still controls the pull-up.

Each pin gets a direction override pair, a pull-up override pair and a value override pair. Each pin also gets a resolved driver enable that the pad ring can use directly. The block synchronises the pad levels before passing them to the SPI core. It also reports whether the slave side is selected. When the SPI is disabled, every override enable is low and the four pins act as plain GPIO.

Top module: `spi_pin_override`

## Requirements
- R1: With `spi_en` low, all direction, pull-up and value override enables and values are 0, and `pin_drive` equals `pin_dir`.
- R2: Pin index order in every 4-bit vector is bit 0 slave select, bit 1 serial clock, bit 2 master-out/slave-in, bit 3 master-in/slave-out. In master mode (`spi_master`=1, enabled), only bit 3 has its direction override enable set, with override value 0.
- R3: In slave mode (`spi_master`=0, enabled), bits 0, 1 and 2 have direction override enable 1 with value 0, and bit 3 has direction override enable 0.
- R4: On every pin whose direction is overridden, the pull-up override enable is 1 and the pull-up override value equals that pin's `pin_port` bit. On every other pin, both are 0.
- R5: In master mode, bits 1 and 2 have value override enable 1, with values `core_sck_out` and `core_mosi_out`. Bits 0 and 3 have value override enable 0 and value 0.
- R6: In slave mode, bit 3 has value override enable 1 with value `core_miso_out`. Bits 0 to 2 have value override enable 0 and value 0.
- R7: `core_pin_in` equals `pad_in` as sampled two rising clock edges earlier. While reset is asserted, it reads all ones.
- R8: `slave_active` is 1 exactly when the SPI is enabled in slave mode and the synchronised slave-select level (`core_pin_in[0]`) is 0.
- R9: A forced pin's `pin_drive` is 0 for any `pin_dir` value. A pin that is not forced has `pin_drive` equal to its `pin_dir` bit, and `pin_dir` has no effect on any override output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_en | input | 1 | SPI enable |
| spi_master | input | 1 | 1 = master role, 0 = slave role |
| pin_dir | input | 4 | Port direction bits (1 = output) |
| pin_port | input | 4 | Port register bits |
| core_sck_out | input | 1 | Serial clock driven by the core |
| core_mosi_out | input | 1 | Master data out from the core |
| core_miso_out | input | 1 | Slave data out from the core |
| pad_in | input | 4 | Raw pad levels |
| dir_ovr_en | output | 4 | Direction override enable |
| dir_ovr_val | output | 4 | Direction override value |
| pull_ovr_en | output | 4 | Pull-up override enable |
| pull_ovr_val | output | 4 | Pull-up override value |
| val_ovr_en | output | 4 | Output value override enable |
| val_ovr_val | output | 4 | Output value override value |
| pin_drive | output | 4 | Resolved pad driver enable |
| core_pin_in | output | 4 | Synchronised pad levels to the core |
| slave_active | output | 1 | Slave selected and active |

## Verification
The hardest case to reach is where a synchronised pad level and a combinational role change meet. One example is slave select already held low in the synchroniser while the role flips from slave to master and back. The override tables cannot show this case, because `slave_active` depends on state two edges old as well as on the current mode bits. The stimulus first drives the pad low and waits exactly two edges. It then toggles `spi_master` and `spi_en` with the pad held steady, and later raises the pad and checks the edge count before deselection shows.

// File: rtl/spi_pinmux_pkg.sv
// Package: shared pin indices and the per-pin override bundle.
// Assumes four SPI pins, always in the index order listed below.
package spi_pinmux_pkg;

    localparam int PIN_COUNT = 4;

    typedef enum int {
        PIN_SS   = 0,
        PIN_SCK  = 1,
        PIN_MOSI = 2,
        PIN_MISO = 3
    } pin_idx_e;

    typedef struct packed {
        logic dir_en;
        logic dir_val;
        logic pull_en;
        logic pull_val;
        logic val_en;
        logic val_val;
        logic drive;
    } pin_ovr_t;

endpackage

// File: rtl/spi_pin_role.sv
// Module: override generator for one SPI pin.
// A pin is forced to input in one role, chosen by INPUT_IN_MASTER. In the
// other role it follows its direction bit. If HAS_CORE_DRIVE is set, its
// output value then comes from the SPI core.
// Assumes spi_en and spi_master are stable register outputs.
module spi_pin_role #(
    parameter bit INPUT_IN_MASTER = 1'b0,
    parameter bit HAS_CORE_DRIVE  = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_en,
    input  logic                      spi_master,
    input  logic                      dir_bit,
    input  logic                      port_bit,
    input  logic                      core_drive,
    output spi_pinmux_pkg::pin_ovr_t  ovr
);
    logic forced;
    logic drives;

    // Decide whether the current role forces this pin in or lets the core drive it.
    always_comb begin
        forced = spi_en & (INPUT_IN_MASTER ? spi_master : ~spi_master);
        drives = spi_en & HAS_CORE_DRIVE & ~forced;
    end

    // Build the override bundle from the role decision.
    always_comb begin
        ovr          = '0;
        ovr.dir_en   = forced;
        ovr.dir_val  = 1'b0;
        ovr.pull_en  = forced;
        ovr.pull_val = forced & port_bit;
        ovr.val_en   = drives;
        ovr.val_val  = drives & core_drive;
        ovr.drive    = ~forced & dir_bit;
    end

    // A forced input keeps the pull-up under port-bit control.
    assert_forced_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr.dir_en |-> (ovr.pull_en && ovr.pull_val == port_bit));

    // A forced input is never driven and never gets a core value.
    assert_forced_undriven_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr.dir_en |-> (!ovr.drive && !ovr.val_en));

    // No override of any kind while the SPI is off.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> (!ovr.dir_en && !ovr.pull_en && !ovr.val_en && ovr.drive == dir_bit));

endmodule

// File: rtl/spi_in_sync.sv
// Module: multi-stage synchroniser for the pad levels routed to the core.
// Assumes pad levels may change asynchronously. Every stage resets to RESET_VAL.
module spi_in_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage;

    // Shift the sampled pad levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= {STAGES{RESET_VAL}};
        end else begin
            stage[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage[k] <= stage[k-1];
            end
        end
    end

    assign q = stage[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            logic [1:0] warm;

            // Count edges since reset so the latency check looks back only at valid samples.
            always_ff @(posedge clk) begin
                if (!rst_n)           warm <= 2'd0;
                else if (warm != 2'd3) warm <= warm + 2'd1;
            end

            assert_sync_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (warm == 2'd3) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/spi_pin_override.sv
// Module: top of the SPI pin override logic.
// Creates one role generator per SPI pin, synchronises the pad levels for
// the core, and derives the slave-selected flag.
// Assumes the index order from spi_pinmux_pkg in every 4-bit vector.
module spi_pin_override #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_en,
    input  logic       spi_master,
    input  logic [3:0] pin_dir,
    input  logic [3:0] pin_port,
    input  logic       core_sck_out,
    input  logic       core_mosi_out,
    input  logic       core_miso_out,
    input  logic [3:0] pad_in,
    output logic [3:0] dir_ovr_en,
    output logic [3:0] dir_ovr_val,
    output logic [3:0] pull_ovr_en,
    output logic [3:0] pull_ovr_val,
    output logic [3:0] val_ovr_en,
    output logic [3:0] val_ovr_val,
    output logic [3:0] pin_drive,
    output logic [3:0] core_pin_in,
    output logic       slave_active
);
    import spi_pinmux_pkg::*;

    localparam int NP = PIN_COUNT;

    logic [NP-1:0] core_drive;
    pin_ovr_t      ovr [NP];

    // Gather the core output values in pin index order; select has none.
    always_comb begin
        core_drive           = '0;
        core_drive[PIN_SCK]  = core_sck_out;
        core_drive[PIN_MOSI] = core_mosi_out;
        core_drive[PIN_MISO] = core_miso_out;
    end

    generate
        for (genvar i = 0; i < NP; i++) begin : g_pin
            localparam bit IN_M  = (i == PIN_MISO);
            localparam bit DRIVE = (i != PIN_SS);

            spi_pin_role #(
                .INPUT_IN_MASTER (IN_M),
                .HAS_CORE_DRIVE  (DRIVE)
            ) u_role (
                .clk        (clk),
                .rst_n      (rst_n),
                .spi_en     (spi_en),
                .spi_master (spi_master),
                .dir_bit    (pin_dir[i]),
                .port_bit   (pin_port[i]),
                .core_drive (core_drive[i]),
                .ovr        (ovr[i])
            );

            assign dir_ovr_en[i]   = ovr[i].dir_en;
            assign dir_ovr_val[i]  = ovr[i].dir_val;
            assign pull_ovr_en[i]  = ovr[i].pull_en;
            assign pull_ovr_val[i] = ovr[i].pull_val;
            assign val_ovr_en[i]   = ovr[i].val_en;
            assign val_ovr_val[i]  = ovr[i].val_val;
            assign pin_drive[i]    = ovr[i].drive;
        end
    endgenerate

    spi_in_sync #(
        .WIDTH     (NP),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({NP{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (core_pin_in)
    );

    // The slave is selected only in slave role with a low synchronised select.
    always_comb begin
        slave_active = spi_en & ~spi_master & ~core_pin_in[PIN_SS];
    end

    // Exactly one forced pin in master role and three in slave role.
    assert_role_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> ($countones(dir_ovr_en) == (spi_master ? 1 : 3)));

    // Forced input and core drive never coincide on one pin.
    assert_role_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_ovr_en & val_ovr_en) == 4'b0000);

    // Only the slave role can report a selected slave.
    assert_slave_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slave_active |-> (spi_en && !spi_master && !core_pin_in[0]));

    // The slave role always drives exactly the data-out pin from the core.
    assert_slave_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (val_ovr_en == 4'b1000));

endmodule

// File: tb/test_spi_pin_override.sv
`timescale 1ns/1ps
module test_spi_pin_override;

    typedef struct packed {
        logic       en;
        logic       master;
        logic [3:0] dir;
        logic [3:0] port;
        logic [2:0] core;      // {sck, mosi, miso}
        logic [3:0] exp_dir;   // expected direction override enables
        logic [3:0] exp_val;   // expected value override enables
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'hF, 4'hA, 3'b111, 4'b0000, 4'b0000},
        '{1'b0, 1'b1, 4'h3, 4'hC, 3'b101, 4'b0000, 4'b0000},
        '{1'b1, 1'b1, 4'hF, 4'h5, 3'b111, 4'b1000, 4'b0110},
        '{1'b1, 1'b1, 4'h0, 4'hF, 3'b010, 4'b1000, 4'b0110},
        '{1'b1, 1'b1, 4'hA, 4'h3, 3'b100, 4'b1000, 4'b0110},
        '{1'b1, 1'b0, 4'hF, 4'hA, 3'b001, 4'b0111, 4'b1000},
        '{1'b1, 1'b0, 4'h0, 4'h5, 3'b110, 4'b0111, 4'b1000},
        '{1'b1, 1'b0, 4'h5, 4'hF, 3'b111, 4'b0111, 4'b1000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_en = 1'b0;
    logic       spi_master = 1'b0;
    logic [3:0] pin_dir = '0;
    logic [3:0] pin_port = '0;
    logic       core_sck_out = 1'b0;
    logic       core_mosi_out = 1'b0;
    logic       core_miso_out = 1'b0;
    logic [3:0] pad_in = 4'hF;
    logic [3:0] dir_ovr_en, dir_ovr_val, pull_ovr_en, pull_ovr_val;
    logic [3:0] val_ovr_en, val_ovr_val, pin_drive, core_pin_in;
    logic       slave_active;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_pin_override i_spi_pin_override (
        .clk, .rst_n, .spi_en, .spi_master, .pin_dir, .pin_port,
        .core_sck_out, .core_mosi_out, .core_miso_out, .pad_in,
        .dir_ovr_en, .dir_ovr_val, .pull_ovr_en, .pull_ovr_val,
        .val_ovr_en, .val_ovr_val, .pin_drive, .core_pin_in, .slave_active
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state, R7 and R8
        repeat (2) @(posedge clk);
        #1;
        chk("R7 reset core_pin_in", core_pin_in, 4'hF);
        chk("R8 reset slave_active", slave_active, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk: R1 to R6 and R9
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            spi_en = VECS[v].en;
            spi_master = VECS[v].master;
            pin_dir = VECS[v].dir;
            pin_port = VECS[v].port;
            {core_sck_out, core_mosi_out, core_miso_out} = VECS[v].core;
            #1;
            chk("R1/R2/R3 dir_ovr_en", dir_ovr_en, VECS[v].exp_dir);
            chk("R2/R3 dir_ovr_val", dir_ovr_val, 4'b0000);
            chk("R4 pull_ovr_en", pull_ovr_en, VECS[v].exp_dir);
            chk("R4 pull_ovr_val", pull_ovr_val, VECS[v].exp_dir & VECS[v].port);
            chk("R5/R6 val_ovr_en", val_ovr_en, VECS[v].exp_val);
            chk("R5/R6 val_ovr_val", val_ovr_val,
                VECS[v].exp_val & {VECS[v].core[0], VECS[v].core[1], VECS[v].core[2], 1'b0});
            chk("R9 pin_drive", pin_drive, ~VECS[v].exp_dir & VECS[v].dir);
        end

        // R7: two-edge latency
        @(negedge clk);
        spi_en = 1'b1; spi_master = 1'b0;
        pad_in = 4'h0;
        @(posedge clk); #1;
        chk("R7 after one edge", core_pin_in, 4'hF);
        @(posedge clk); #1;
        chk("R7 after two edges", core_pin_in, 4'h0);
        chk("R8 selected slave", slave_active, 1'b1);

        // R8: a role change with select held low
        @(negedge clk) spi_master = 1'b1;
        #1 chk("R8 master role", slave_active, 1'b0);
        @(negedge clk) spi_master = 1'b0; spi_en = 1'b0;
        #1 chk("R8 disabled", slave_active, 1'b0);
        @(negedge clk) spi_en = 1'b1;
        #1 chk("R8 re-enabled slave", slave_active, 1'b1);

        // R8: deselect visible only after the synchroniser
        @(negedge clk) pad_in = 4'b0001;
        @(posedge clk); #1;
        chk("R8 deselect one edge", slave_active, 1'b1);
        @(posedge clk); #1;
        chk("R8 deselect two edges", slave_active, 1'b0);
        chk("R7 pattern", core_pin_in, 4'b0001);

        // R9: the direction bit has no effect on overrides in slave mode
        @(negedge clk) pin_dir = 4'hF; pin_port = 4'h0;
        #1;
        chk("R9 forced drive", pin_drive, 4'b1000);
        chk("R9 dir_ovr_en", dir_ovr_en, 4'b0111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule